// File: doc/BRIEF.md
# Receiver Polling Wake-Up Scheduler

This block drives a low-power radio receiver through a repeating polling cycle. A master period holds one listening slot for each enabled channel, in channel order, followed by an off phase in which the receiver is powered down. All durations are counted in ticks of an external timebase. Each channel is tagged with one of two receiver configurations, A or B, each with its own slot length. The sum of the slot lengths plus the off time gives the master period.

A fast fall-back mode saves power when no signal is present. In this mode every slot uses the configuration-A length. A channel's slot ends early, with the receiver switched off, in three cases: the external demodulator reports no bit-stream synchronisation within a time-out, synchronisation is lost, or the wake-up pattern fails after synchronisation. An early end never shortens the slot timer, so the master period stays constant. A wake-up pattern match on a listening channel stops polling. The receiver is then held on that channel with a sticky interrupt raised until software clears it. Clearing the interrupt restarts polling from channel 0.

All settings are sampled only when a master period starts. A tick in the single restart cycle that follows reset or an interrupt clear is not counted. The timebase is expected to tick at most once every two clocks.

Top module: `rx_poll_sched`

## Requirements
- R1: During reset `rx_en`, `wake_irq` and `ch_sel` are 0. On the first clock after reset the first period starts, and channel 0 is listening (`rx_en`=1).
- R2: All timing and channel settings are sampled at the start of a master period only. A change in the middle of a period first takes effect at the next period.
- R3: In normal mode, slot i lasts `on_time_b` ticks if bit i of `cfg_b_mask` is 1, and `on_time_a` ticks otherwise. A length of 0 counts as 1. During slot i, `cfg_sel` equals that mask bit and `rx_en`=1.
- R4: After the last slot an off phase of `off_time` ticks follows (0 counts as 1), with `rx_en`=0 and `cfg_sel`=0. The master period is the sum of all slot lengths plus the off time.
- R5: `ch_sel` advances by one only at a slot boundary. It keeps the last channel through the off phase and returns to 0 when a period starts.
- R6: In fast mode every slot lasts `on_time_a` ticks, whatever the mask says. `cfg_sel` still follows the mask.
- R7: In fast mode, if no `sync_found` strobe arrives within `sync_timeout` ticks of the slot start (0 counts as 1), `rx_en` falls at that tick and stays low for the rest of the slot.
- R8: In fast mode, a `sync_found` strobe keeps the channel listening past the time-out. A later `sync_lost` or `wu_mismatch` strobe in the same slot drops `rx_en` from the next clock until the slot ends.
- R9: An early end of a slot does not move any later slot boundary. The next channel starts listening at the normal boundary.
- R10: A `wu_match` strobe while listening holds `rx_en`=1, freezes `ch_sel` and `cfg_sel`, and sets `wake_irq`. Ticks and strobes are then ignored. An `irq_clear` strobe drops `wake_irq`, and polling restarts from channel 0 one clock later.
- R11: Strobes have no effect while the receiver is off, whether in the off phase or in an ended slot. In normal mode, `sync_lost` and `wu_mismatch` never end a slot. A `sync_lost` with no earlier `sync_found` in that slot has no effect.
- R12: A channel count of 0 keeps `rx_en` at 0 while periods of `off_time` ticks keep running. A count above the channel limit is clamped to the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| fast_mode | input | 1 | 1 selects fast fall-back operation |
| on_time_a | input | TW | Slot length of configuration A, in ticks |
| on_time_b | input | TW | Slot length of configuration B, in ticks |
| off_time | input | TW | Off phase length, in ticks |
| sync_timeout | input | TW | Synchronisation time-out, in ticks |
| ch_count | input | CW | Number of channels polled |
| cfg_b_mask | input | MAX_CH | Bit i set: channel i uses configuration B |
| sync_found | input | 1 | Demodulator reports bit-stream synchronisation |
| sync_lost | input | 1 | Demodulator reports synchronisation lost |
| wu_match | input | 1 | Wake-up pattern matched |
| wu_mismatch | input | 1 | Wake-up pattern failed |
| irq_clear | input | 1 | Software clears the wake-up interrupt |
| rx_en | output | 1 | Receiver power enable |
| ch_sel | output | IW | Current channel index |
| cfg_sel | output | 1 | 1 when configuration B is in use |
| wake_irq | output | 1 | Sticky wake-up interrupt |

## Verification
The schedule is first run in normal mode with a mixed A/B mask. This separates per-configuration slot lengths from a single shared length and shows where the off phase falls. A settings change in the middle of a period shows whether the settings are sampled only at the period start. Fast mode is then run three ways: with no strobes (time-out aborts), with sync followed by a mismatch or loss, and with a loss but no prior sync. These tell the three ways a slot can end early apart from the cases that must leave it alone, while the position-based reference model confirms that later boundaries do not move. Wake matches are applied while listening, in an ended slot and in the off phase, followed by a zero channel count and an over-range count. These tell the hold-and-restart path apart from ignored strobes and cover the clamp.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_SLOT = 2'd1,
    PH_OFF  = 2'd2,
    PH_HOLD = 2'd3
  } phase_t;

  // a programmed length of zero behaves as one tick
  function automatic int unsigned eff_len(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // true when the coming tick completes an interval of raw_len ticks
  function automatic logic is_last_tick(input int unsigned done_ticks,
                                        input int unsigned raw_len);
    return (done_ticks + 1) >= eff_len(raw_len);
  endfunction

  function automatic int unsigned clamp_count(input int unsigned raw,
                                              input int unsigned limit);
    return (raw > limit) ? limit : raw;
  endfunction

endpackage

// File: rtl/sched_slot_timer.sv
module sched_slot_timer
  import sched_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [TW-1:0] len,
  output logic          expire
);

  logic [TW-1:0] count_q;

  assign expire = tick && !restart && is_last_tick(32'(count_q), 32'(len));

  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '0;
    else if (restart)  count_q <= '0;
    else if (tick)     count_q <= expire ? '0 : count_q + 1'b1;
  end

  AST_TIMER_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (32'(count_q) < eff_len(32'(len)))); // R4

  AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == '0)); // R9

endmodule

// File: rtl/sched_abort_mon.sv
module sched_abort_mon
  import sched_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_en,
  input  logic          clear,
  input  logic          active,
  input  logic          tick,
  input  logic [TW-1:0] sync_to,
  input  logic          sync_found,
  input  logic          sync_lost,
  input  logic          wu_mismatch,
  output logic          abort
);

  logic [TW-1:0] wait_q;
  logic          synced_q;
  logic          timed_out;
  logic          broken;

  assign timed_out = tick && !synced_q && !sync_found &&
                     is_last_tick(32'(wait_q), 32'(sync_to));
  assign broken    = synced_q && (sync_lost || wu_mismatch);
  assign abort     = active && fast_en && !clear && (timed_out || broken);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wait_q   <= '0;
      synced_q <= 1'b0;
    end else if (active) begin
      if (sync_found)          synced_q <= 1'b1;
      if (tick && !synced_q)   wait_q   <= wait_q + 1'b1;
    end
  end

  AST_SYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (synced_q && !clear) |=> synced_q); // R8

endmodule

// File: rtl/rx_poll_sched.sv
module rx_poll_sched
  import sched_pkg::*;
#(
  parameter  int MAX_CH = 8,
  parameter  int TW     = 12,
  localparam int CW     = $clog2(MAX_CH + 1),
  localparam int IW     = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fast_mode,
  input  logic [TW-1:0]     on_time_a,
  input  logic [TW-1:0]     on_time_b,
  input  logic [TW-1:0]     off_time,
  input  logic [TW-1:0]     sync_timeout,
  input  logic [CW-1:0]     ch_count,
  input  logic [MAX_CH-1:0] cfg_b_mask,
  input  logic              sync_found,
  input  logic              sync_lost,
  input  logic              wu_match,
  input  logic              wu_mismatch,
  input  logic              irq_clear,
  output logic              rx_en,
  output logic [IW-1:0]     ch_sel,
  output logic              cfg_sel,
  output logic              wake_irq
);

  phase_t            phase_q;
  logic [IW-1:0]     idx_q;
  logic              aborted_q;
  logic              irq_q;

  // settings captured at the start of each master period
  logic [TW-1:0]     s_on_a, s_on_b, s_off, s_sync_to;
  logic [CW-1:0]     s_cnt;
  logic [MAX_CH-1:0] s_mask;
  logic              s_fast;

  // named internal events
  logic          in_slot, in_hold, listen, wake_hit;
  logic          cfg_b_now, last_slot, take_snapshot, restart;
  logic          t_expire, slot_end, off_end, abort_evt, mon_clear;
  logic [TW-1:0] slot_len, timer_len;

  assign in_slot       = (phase_q == PH_SLOT);
  assign in_hold       = (phase_q == PH_HOLD);
  assign listen        = in_slot && !aborted_q;
  assign wake_hit      = listen && wu_match;
  assign cfg_b_now     = s_mask[idx_q];
  assign slot_len      = (s_fast || !cfg_b_now) ? s_on_a : s_on_b;
  assign timer_len     = (phase_q == PH_OFF) ? s_off : slot_len;
  assign last_slot     = (32'(idx_q) + 1) >= clamp_count(32'(s_cnt), MAX_CH);
  assign slot_end      = in_slot && t_expire;
  assign off_end       = (phase_q == PH_OFF) && t_expire;
  assign take_snapshot = (phase_q == PH_LOAD) || off_end;
  assign restart       = (phase_q == PH_LOAD);
  assign mon_clear     = !in_slot || slot_end;

  sched_slot_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart),
    .len     (timer_len),
    .expire  (t_expire)
  );

  sched_abort_mon #(.TW(TW)) u_abort (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_en     (s_fast),
    .clear       (mon_clear),
    .active      (listen),
    .tick        (tick),
    .sync_to     (s_sync_to),
    .sync_found  (sync_found),
    .sync_lost   (sync_lost),
    .wu_mismatch (wu_mismatch),
    .abort       (abort_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_on_a    <= '0;
      s_on_b    <= '0;
      s_off     <= '0;
      s_sync_to <= '0;
      s_cnt     <= '0;
      s_mask    <= '0;
      s_fast    <= 1'b0;
    end else if (take_snapshot) begin
      s_on_a    <= on_time_a;
      s_on_b    <= on_time_b;
      s_off     <= off_time;
      s_sync_to <= sync_timeout;
      s_cnt     <= ch_count;
      s_mask    <= cfg_b_mask;
      s_fast    <= fast_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_LOAD;
      idx_q     <= '0;
      aborted_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          idx_q     <= '0;
          aborted_q <= 1'b0;
          phase_q   <= (ch_count == '0) ? PH_OFF : PH_SLOT;
        end
        PH_SLOT: begin
          if (wake_hit) begin
            phase_q <= PH_HOLD;
            irq_q   <= 1'b1;
          end else if (slot_end) begin
            aborted_q <= 1'b0;
            if (last_slot) phase_q <= PH_OFF;
            else           idx_q   <= idx_q + 1'b1;
          end else if (abort_evt) begin
            aborted_q <= 1'b1;
          end
        end
        PH_OFF: begin
          if (off_end) begin
            idx_q     <= '0;
            aborted_q <= 1'b0;
            phase_q   <= (ch_count == '0) ? PH_OFF : PH_SLOT;
          end
        end
        PH_HOLD: begin
          if (irq_clear) begin
            irq_q   <= 1'b0;
            phase_q <= PH_LOAD;
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  assign rx_en    = listen || in_hold;
  assign ch_sel   = idx_q;
  assign cfg_sel  = (in_slot || in_hold) && cfg_b_now;
  assign wake_irq = irq_q;

  AST_SETTINGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !take_snapshot |=> ($stable(s_on_a) && $stable(s_cnt) && $stable(s_fast) && $stable(s_off))); // R2

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_OFF) && !off_end) |=> !rx_en); // R4

  AST_CH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && !slot_end) |=> $stable(ch_sel)); // R5

  AST_ABORT_STAYS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && (aborted_q || abort_evt) && !slot_end && !wake_hit) |=> !rx_en); // R7

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !irq_clear) |=> (rx_en && wake_irq && $stable(ch_sel))); // R10

  AST_IRQ_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(wake_hit)); // R10

  AST_ZERO_CH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (take_snapshot && (ch_count == '0)) |=> !rx_en); // R12

endmodule

// File: tb/rx_poll_sched_tb.sv
module rx_poll_sched_tb;

  localparam int MAX_CH = 8;
  localparam int TW     = 12;
  localparam int CW     = 4;
  localparam int IW     = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              rst_n, tick, fast_mode;
  logic [TW-1:0]     on_time_a, on_time_b, off_time, sync_timeout;
  logic [CW-1:0]     ch_count;
  logic [MAX_CH-1:0] cfg_b_mask;
  logic              sync_found, sync_lost, wu_match, wu_mismatch, irq_clear;
  logic              rx_en, cfg_sel, wake_irq;
  logic [IW-1:0]     ch_sel;

  rx_poll_sched #(.MAX_CH(MAX_CH), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fast_mode(fast_mode),
    .on_time_a(on_time_a), .on_time_b(on_time_b), .off_time(off_time),
    .sync_timeout(sync_timeout), .ch_count(ch_count), .cfg_b_mask(cfg_b_mask),
    .sync_found(sync_found), .sync_lost(sync_lost), .wu_match(wu_match),
    .wu_mismatch(wu_mismatch), .irq_clear(irq_clear),
    .rx_en(rx_en), .ch_sel(ch_sel), .cfg_sel(cfg_sel), .wake_irq(wake_irq)
  );

  typedef struct {
    logic  rx;
    int    ch;
    logic  cfg;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  logic tick_seen = 1'b0;

  // reference model: position inside the current master period
  int                pos;
  int                c_a, c_b, c_off, c_cnt, c_to;
  logic [MAX_CH-1:0] c_mask;
  logic              c_fast;
  int                m_slot, m_off, m_hold_ch;
  bit                m_synced, m_killed, m_hold;
  logic              m_hold_cfg;

  function automatic int e1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int n_ch();
    return (c_cnt > MAX_CH) ? MAX_CH : c_cnt;
  endfunction

  function automatic int slot_ticks(input int i);
    if (c_fast) return e1(c_a);
    return c_mask[i] ? e1(c_b) : e1(c_a);
  endfunction

  function automatic int period_ticks();
    int sum = 0;
    for (int i = 0; i < n_ch(); i++) sum += slot_ticks(i);
    return sum + e1(c_off);
  endfunction

  function automatic void locate();
    int acc = 0;
    m_slot = -1;
    m_off  = 0;
    for (int i = 0; i < n_ch(); i++) begin
      if (m_slot < 0 && pos < acc + slot_ticks(i)) begin
        m_slot = i;
        m_off  = pos - acc;
      end
      acc += slot_ticks(i);
    end
  endfunction

  function automatic void latch_cfg();
    c_a = int'(on_time_a); c_b = int'(on_time_b); c_off = int'(off_time);
    c_to = int'(sync_timeout); c_cnt = int'(ch_count);
    c_mask = cfg_b_mask; c_fast = fast_mode;
  endfunction

  function automatic logic model_rx();
    if (m_hold) return 1'b1;
    if (m_slot < 0) return 1'b0;
    if (!c_fast) return 1'b1;
    if (m_killed) return 1'b0;
    if (!m_synced && m_off >= e1(c_to)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic exp_t build(input string tag);
    exp_t e;
    e.rx  = model_rx();
    e.irq = m_hold;
    e.tag = tag;
    if (m_hold) begin
      e.ch = m_hold_ch; e.cfg = m_hold_cfg;
    end else if (m_slot >= 0) begin
      e.ch = m_slot; e.cfg = c_mask[m_slot];
    end else begin
      e.ch = (n_ch() == 0) ? 0 : n_ch() - 1; e.cfg = 1'b0;
    end
    return e;
  endfunction

  function automatic void model_restart();
    pos = 0;
    latch_cfg();
    m_hold = 0; m_synced = 0; m_killed = 0;
    locate();
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (rx_en !== e.rx || int'(ch_sel) != e.ch || cfg_sel !== e.cfg || wake_irq !== e.irq) begin
      fails++;
      $display("FAIL %s: rx_en=%0b ch_sel=%0d cfg_sel=%0b wake_irq=%0b expected rx_en=%0b ch_sel=%0d cfg_sel=%0b wake_irq=%0b",
               e.tag, rx_en, ch_sel, cfg_sel, wake_irq, e.rx, e.ch, e.cfg, e.irq);
    end
  endtask

  // monitor: compares one expected item after every consumed tick
  always @(posedge clk) tick_seen <= tick;
  always @(negedge clk) begin
    if (tick_seen && q.size() > 0) compare(q.pop_front());
  end

  // driver: advances the model by one tick and pushes the expected outputs
  task automatic do_tick(input string tag);
    int prev;
    if (!m_hold) begin
      prev = m_slot;
      pos++;
      if (pos >= period_ticks()) begin
        pos = 0;
        latch_cfg();
      end
      locate();
      if (m_slot != prev || pos == 0) begin
        m_synced = 0; m_killed = 0;
      end
    end
    q.push_back(build(tag));
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tick_until(input int slot, input int off, input string tag);
    for (int n = 0; n < 200; n++) begin
      if (m_slot == slot && m_off == off && !m_hold) break;
      do_tick(tag);
    end
  endtask

  // kind: 0 sync_found, 1 sync_lost, 2 wu_mismatch, 3 wu_match
  task automatic strobe(input int kind, input string tag);
    logic was_rx;
    exp_t cur;
    was_rx = model_rx();
    cur    = build(tag);
    case (kind)
      0: sync_found  = 1'b1;
      1: sync_lost   = 1'b1;
      2: wu_mismatch = 1'b1;
      default: wu_match = 1'b1;
    endcase
    @(negedge clk);
    sync_found = 1'b0; sync_lost = 1'b0; wu_mismatch = 1'b0; wu_match = 1'b0;
    if (!m_hold && was_rx) begin
      case (kind)
        0: m_synced = 1;
        1, 2: if (c_fast && m_synced) m_killed = 1;
        default: begin
          m_hold = 1; m_hold_ch = cur.ch; m_hold_cfg = cur.cfg;
        end
      endcase
    end
    compare(build(tag));
  endtask

  task automatic clear_irq();
    exp_t e;
    irq_clear = 1'b1;
    @(negedge clk) irq_clear = 1'b0;
    e.rx = 1'b0; e.ch = m_hold_ch; e.cfg = 1'b0; e.irq = 1'b0; e.tag = "R10";
    compare(e);
    @(negedge clk);
    model_restart();
    compare(build("R10"));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    finish_run();
  end

  initial begin
    exp_t e;
    rst_n = 1'b0; tick = 1'b0; fast_mode = 1'b0;
    on_time_a = 12'd3; on_time_b = 12'd5; off_time = 12'd4; sync_timeout = 12'd2;
    ch_count = 4'd3; cfg_b_mask = 8'b0000_0010;
    sync_found = 1'b0; sync_lost = 1'b0; wu_match = 1'b0; wu_mismatch = 1'b0; irq_clear = 1'b0;
    repeat (3) @(negedge clk);
    e.rx = 1'b0; e.ch = 0; e.cfg = 1'b0; e.irq = 1'b0; e.tag = "R1 reset";
    compare(e);
    rst_n = 1'b1;
    @(negedge clk);
    model_restart();
    compare(build("R1"));

    // normal mode, mixed configurations: slots 3,5,3 then off 4
    repeat (30) do_tick("R3 R4 R5");

    // settings changed mid-period apply from the next period only
    tick_until(1, 0, "R3");
    on_time_a = 12'd2; off_time = 12'd6;
    repeat (20) do_tick("R2");

    // normal mode ignores loss and mismatch
    tick_until(0, 1, "R2");
    strobe(1, "R11");
    strobe(2, "R11");
    repeat (3) do_tick("R11");

    // fast mode: all slots use length A, time-outs end slots early
    fast_mode = 1'b1; on_time_a = 12'd4; on_time_b = 12'd7; off_time = 12'd3;
    sync_timeout = 12'd2; cfg_b_mask = 8'b0000_0010; ch_count = 4'd3;
    repeat (30) do_tick("R6 R7 R9");

    // sync holds the slot, mismatch ends it
    tick_until(1, 0, "R7");
    strobe(0, "R8");
    repeat (3) do_tick("R8");
    strobe(2, "R8");
    tick_until(2, 0, "R9");
    strobe(1, "R11");
    strobe(0, "R8");
    strobe(1, "R8");
    repeat (6) do_tick("R9");

    // match ignored in an ended slot
    tick_until(0, 3, "R9");
    strobe(3, "R11");

    // wake-up: hold, ignore, clear, restart
    tick_until(1, 1, "R7");
    strobe(3, "R10");
    repeat (5) do_tick("R10");
    strobe(2, "R10");
    clear_irq();

    // match ignored in the off phase
    tick_until(-1, 0, "R9");
    strobe(3, "R11");

    // zero channels
    ch_count = 4'd0; off_time = 12'd5; fast_mode = 1'b0;
    repeat (16) do_tick("R12");
    strobe(3, "R12");

    // over-range count clamps to the limit
    ch_count = 4'd10; cfg_b_mask = 8'b0; on_time_a = 12'd1; off_time = 12'd2;
    repeat (24) do_tick("R12");

    @(negedge clk);
    finish_run();
  end

endmodule